// File: doc/BRIEF.md
# SPI Register Front End with FIFO Status and Interrupt

This block sits between a 32-bit register bus and a serial shift engine of an SPI controller. It decodes a bank of word-aligned registers. It holds a transmit queue and a receive queue of equal depth. It derives occupancy flags from the two queues and merges them with per-bit enables into a single interrupt line. A bus write to the transmit data register queues a word for the engine. A bus read of the receive data register takes the oldest received word. The engine drains the transmit queue and fills the receive queue through plain FIFO ports. It reports the end of a transfer with a one-cycle pulse.

Software sets up the controller by writing the control and period registers, which drive the engine directly. It enables the interrupt causes it cares about and services the queues when the interrupt fires. The two sticky causes, receive overflow and transfer done, stay set until software writes a 1 to them. The live queue occupancies can be read from the test register. Each queue can also be emptied through write-1 strobes in that register.

Top module: `spi_regfront`

## Requirements
- R1: After reset the status register (offset 0x14) reads 0x01, the test register (offset 0x1C) reads 0, the transmit queue is empty to the engine and irq is low.
- R2: A write to offset 0x04 appends the word to the transmit queue, and the test register bits 4:0 show the transmit occupancy. The engine sees the oldest word on eng_tx_data with eng_tx_valid high, and eng_tx_pop advances to the next word in write order.
- R3: A write to offset 0x04 while the transmit queue holds 16 words is dropped: occupancy stays 16 and the word never reaches the engine.
- R4: An eng_rx_push appends eng_rx_data to the receive queue, and test register bits 9:5 show the receive occupancy. Reads of offset 0x00 return the received words oldest first and remove each one.
- R5: A read of offset 0x00 while the receive queue is empty returns 0 and leaves the receive occupancy at 0.
- R6: The status level flags are live: bit 0 is set when the transmit queue is empty, bit 1 when it holds 8 or more words, and bit 2 when it holds 16. Bit 3 is set when the receive queue holds at least one word, bit 4 when it holds 8 or more, and bit 5 when it holds 16.
- R7: Status bit 6 (receive overflow) is set when eng_rx_push arrives with 16 words queued, and the arriving word is discarded. The bit holds until a status write with bit 6 set or a receive queue flush clears it.
- R8: Status bit 7 (transfer done) is set by an eng_done pulse and stays set. A status write with bit 7 set clears it, and a status write with bit 7 at 0 leaves it unchanged.
- R9: The interrupt enable register (offset 0x0C, bits 7:0) lines up bit for bit with the status register. irq is high exactly when some status bit and its enable bit are both set.
- R10: Writing the test register with bit 22 set empties the transmit queue. Writing it with bit 23 set empties the receive queue and clears the overflow flag. Neither strobe affects the other queue.
- R11: The control register (offset 0x08, 32 bits) and the period register (offset 0x18, bits 14:0) read back what was written and drive ctrl_o and period_o. Unused period bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_rd | input | 1 | Read qualifier for the access |
| bus_addr | input | 5 | Byte address, bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| eng_tx_data | output | 32 | Oldest queued transmit word |
| eng_tx_valid | output | 1 | Transmit queue holds a word |
| eng_tx_pop | input | 1 | Engine consumes the transmit head |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_done | input | 1 | One-cycle transfer-complete pulse |
| ctrl_o | output | 32 | Control register contents |
| period_o | output | 15 | Period register contents |
| irq | output | 1 | Combined interrupt |

## Verification
A write or engine event at a rising edge takes effect at that edge. The new occupancy, status, irq and engine-side head are therefore due in the cycle right after the strobe. Read data comes from a combinational mux, so it is due within the cycle the read is driven, and the removal of a received word happens at the closing edge. The bench drives every strobe on a falling edge and releases it on the next falling edge. It samples results at that second falling edge, or a delta after driving in the case of read data. Each value is taken exactly one register stage after its cause and away from any edge.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  // register index = byte address bits 4:2
  localparam int unsigned IDX_RXD  = 0;
  localparam int unsigned IDX_TXD  = 1;
  localparam int unsigned IDX_CTRL = 2;
  localparam int unsigned IDX_IEN  = 3;
  localparam int unsigned IDX_DMA  = 4;
  localparam int unsigned IDX_STAT = 5;
  localparam int unsigned IDX_PER  = 6;
  localparam int unsigned IDX_TEST = 7;

  // status / enable bit positions
  localparam int unsigned ST_TXEMPTY = 0;
  localparam int unsigned ST_TXHALF  = 1;
  localparam int unsigned ST_TXFULL  = 2;
  localparam int unsigned ST_RXRDY   = 3;
  localparam int unsigned ST_RXHALF  = 4;
  localparam int unsigned ST_RXFULL  = 5;
  localparam int unsigned ST_RXOVF   = 6;
  localparam int unsigned ST_DONE    = 7;

  // test register fields
  localparam int unsigned TST_TXCNT_LSB = 0;
  localparam int unsigned TST_RXCNT_LSB = 5;
  localparam int unsigned TST_CNT_W     = 5;
  localparam int unsigned TST_TXFLUSH   = 22;
  localparam int unsigned TST_RXFLUSH   = 23;

  localparam int unsigned PERIOD_W = 15;

  function automatic logic level_at_least(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  // six live level flags from the two occupancies
  function automatic logic [5:0] level_flags(input int unsigned tx_cnt,
                                             input int unsigned rx_cnt,
                                             input int unsigned depth);
    logic [5:0] f;
    f[ST_TXEMPTY] = (tx_cnt == 0);
    f[ST_TXHALF]  = level_at_least(tx_cnt, depth / 2);
    f[ST_TXFULL]  = level_at_least(tx_cnt, depth);
    f[ST_RXRDY]   = level_at_least(rx_cnt, 1);
    f[ST_RXHALF]  = level_at_least(rx_cnt, depth / 2);
    f[ST_RXFULL]  = level_at_least(rx_cnt, depth);
    return f;
  endfunction

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             push_drop
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             push_ok, pop_ok;

  assign push_ok   = push && (count != FULL_CNT);
  assign pop_ok    = pop && (count != '0);
  assign push_drop = push && (count == FULL_CNT);
  assign head      = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

endmodule

// File: rtl/spi_rf_stat.sv
module spi_rf_stat
  import spi_rf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic          rx_drop,
  input  logic          done_pulse,
  input  logic [7:0]    w1c,
  input  logic          rx_flush,
  input  logic [7:0]    ien,
  output logic [7:0]    status,
  output logic          irq
);

  logic ovf_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (rx_drop)                          ovf_q <= 1'b1;
      else if (w1c[ST_RXOVF] || rx_flush)   ovf_q <= 1'b0;
      if (done_pulse)                       done_q <= 1'b1;
      else if (w1c[ST_DONE])                done_q <= 1'b0;
    end
  end

  always_comb begin
    status[5:0]       = level_flags(32'(tx_cnt), 32'(rx_cnt), DEPTH);
    status[ST_RXOVF]  = ovf_q;
    status[ST_DONE]   = done_q;
  end

  assign irq = |(status & ien);

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_rf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned DW = 32,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [4:0]          bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [DW-1:0]       eng_tx_data,
  output logic                eng_tx_valid,
  input  logic                eng_tx_pop,
  input  logic                eng_rx_push,
  input  logic [DW-1:0]       eng_rx_data,
  input  logic                eng_done,
  output logic [DW-1:0]       ctrl_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                irq
);

  // named internal events (observed by the checker)
  logic          wr_en, rd_en;
  logic [2:0]    idx;
  logic          tx_wr_evt, rx_rd_evt, tx_flush, rx_flush;
  logic [7:0]    stat_w1c;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_head;
  logic          tx_drop_unused, rx_drop;
  logic [7:0]    status, ien_q;
  logic [DW-1:0] ctrl_q;
  logic [PERIOD_W-1:0] period_q;

  assign idx       = bus_addr[4:2];
  assign wr_en     = bus_sel && bus_wr;
  assign rd_en     = bus_sel && bus_rd;
  assign tx_wr_evt = wr_en && (idx == 3'(IDX_TXD));
  assign rx_rd_evt = rd_en && (idx == 3'(IDX_RXD));
  assign tx_flush  = wr_en && (idx == 3'(IDX_TEST)) && bus_wdata[TST_TXFLUSH];
  assign rx_flush  = wr_en && (idx == 3'(IDX_TEST)) && bus_wdata[TST_RXFLUSH];
  assign stat_w1c  = (wr_en && (idx == 3'(IDX_STAT))) ? bus_wdata[7:0] : 8'h00;

  spi_rf_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (tx_wr_evt),
    .push_data (bus_wdata),
    .pop       (eng_tx_pop),
    .head      (eng_tx_data),
    .count     (tx_cnt),
    .push_drop (tx_drop_unused)
  );

  spi_rf_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (eng_rx_push),
    .push_data (eng_rx_data),
    .pop       (rx_rd_evt),
    .head      (rx_head),
    .count     (rx_cnt),
    .push_drop (rx_drop)
  );

  assign eng_tx_valid = (tx_cnt != '0);

  spi_rf_stat #(.DEPTH(DEPTH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .rx_drop    (rx_drop),
    .done_pulse (eng_done),
    .w1c        (stat_w1c),
    .rx_flush   (rx_flush),
    .ien        (ien_q),
    .status     (status),
    .irq        (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      period_q <= '0;
    end else if (wr_en) begin
      if (idx == 3'(IDX_CTRL)) ctrl_q   <= bus_wdata;
      if (idx == 3'(IDX_IEN))  ien_q    <= bus_wdata[7:0];
      if (idx == 3'(IDX_PER))  period_q <= bus_wdata[PERIOD_W-1:0];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (idx)
        3'(IDX_RXD):  bus_rdata = (rx_cnt != '0) ? rx_head : '0;
        3'(IDX_CTRL): bus_rdata = ctrl_q;
        3'(IDX_IEN):  bus_rdata = {24'h0, ien_q};
        3'(IDX_STAT): bus_rdata = {24'h0, status};
        3'(IDX_PER):  bus_rdata = DW'(period_q);
        3'(IDX_TEST): begin
          bus_rdata[TST_TXCNT_LSB +: TST_CNT_W] = TST_CNT_W'(tx_cnt);
          bus_rdata[TST_RXCNT_LSB +: TST_CNT_W] = TST_CNT_W'(rx_cnt);
        end
        default:      bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_wr_evt,
  input logic          rx_rd_evt,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic [7:0]    stat_w1c,
  input logic          eng_tx_pop,
  input logic          eng_rx_push,
  input logic          eng_done,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    status,
  input logic [7:0]    ien,
  input logic          irq
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // R3
  tx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL_CNT);

  // R2
  tx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_evt && tx_cnt != FULL_CNT && !eng_tx_pop && !tx_flush)
    |=> tx_cnt == $past(tx_cnt) + 1'b1);

  // R3
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_evt && tx_cnt == FULL_CNT && !eng_tx_pop && !tx_flush)
    |=> tx_cnt == FULL_CNT);

  // R5
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_evt && rx_cnt == '0 && !eng_rx_push) |=> rx_cnt == '0);

  // R6
  tx_full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> (status[1] && !status[0]));

  // R7
  rx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_cnt == FULL_CNT) |=> status[6]);

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> status[7]);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !stat_w1c[7]) |=> status[7]);

  // R10
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0 && !status[6]));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 8'h00) |-> !irq);

endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_wr_evt   (tx_wr_evt),
  .rx_rd_evt   (rx_rd_evt),
  .tx_flush    (tx_flush),
  .rx_flush    (rx_flush),
  .stat_w1c    (stat_w1c),
  .eng_tx_pop  (eng_tx_pop),
  .eng_rx_push (eng_rx_push),
  .eng_done    (eng_done),
  .tx_cnt      (tx_cnt),
  .rx_cnt      (rx_cnt),
  .status      (status),
  .ien         (ien_q),
  .irq         (irq)
);

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb;

  localparam int CLK_P = 10;
  localparam logic [4:0] A_RXD = 5'h00, A_TXD = 5'h04, A_CTRL = 5'h08, A_IEN = 5'h0C,
                         A_STAT = 5'h14, A_PER = 5'h18, A_TEST = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] eng_tx_data;
  logic        eng_tx_valid;
  logic        eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0;
  logic [31:0] eng_rx_data = '0;
  logic [31:0] ctrl_o;
  logic [14:0] period_o;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid), .eng_tx_pop(eng_tx_pop),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_done(eng_done),
    .ctrl_o(ctrl_o), .period_o(period_o), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk);
    eng_rx_push = 1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 0;
  endtask

  task automatic tx_pop(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk(req, {31'h0, eng_tx_valid}, 32'h1);
    chk(req, eng_tx_data, exp);
    eng_tx_pop = 1;
    @(negedge clk);
    eng_tx_pop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(A_STAT, d); chk("R1 status", d, 32'h01);
    bus_read(A_TEST, d); chk("R1 test", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, eng_tx_valid}, 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) bus_write(A_TXD, 32'h100 + i);
    bus_read(A_TEST, d); chk("R2 tx count", d, 32'd3);
    bus_read(A_STAT, d); chk("R6 tx nonempty", d, 32'h00);
    for (int i = 0; i < 3; i++) tx_pop("R2 order", 32'h100 + i);
    chk("R2 drained", {31'h0, eng_tx_valid}, 32'h0);
    for (int i = 0; i < 8; i++) bus_write(A_TXD, 32'h200 + i);
    bus_read(A_STAT, d); chk("R6 tx half", d, 32'h02);
    for (int i = 8; i < 16; i++) bus_write(A_TXD, 32'h200 + i);
    bus_read(A_STAT, d); chk("R6 tx full", d, 32'h06);
    bus_write(A_TXD, 32'hDEAD);
    bus_read(A_TEST, d); chk("R3 count held", d, 32'd16);
    for (int i = 0; i < 16; i++) tx_pop("R3 no dropped word", 32'h200 + i);
    chk("R3 empty after", {31'h0, eng_tx_valid}, 32'h0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) rx_push(32'hA0 + i);
    bus_read(A_TEST, d); chk("R4 rx count", d, 32'd3 << 5);
    bus_read(A_STAT, d); chk("R6 rx ready", d, 32'h09);
    for (int i = 0; i < 3; i++) begin
      bus_read(A_RXD, d); chk("R4 rx order", d, 32'hA0 + i);
    end
    bus_read(A_RXD, d); chk("R5 empty read", d, 32'h0);
    bus_read(A_TEST, d); chk("R5 count still 0", d, 32'h0);
    for (int i = 0; i < 16; i++) rx_push(32'hB00 + i);
    bus_read(A_STAT, d); chk("R6 rx full", d, 32'h39);
    rx_push(32'hBAD);
    bus_read(A_STAT, d); chk("R7 overflow set", d, 32'h79);
    bus_write(A_STAT, 32'h40);
    bus_read(A_STAT, d); chk("R7 overflow w1c", d, 32'h39);
    for (int i = 0; i < 16; i++) begin
      bus_read(A_RXD, d); chk("R7 dropped word absent", d, 32'hB00 + i);
    end
    bus_read(A_STAT, d); chk("R6 rx empty", d, 32'h01);
  endtask

  task automatic t_done();
    logic [31:0] d;
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    repeat (3) @(negedge clk);
    bus_read(A_STAT, d); chk("R8 done sticky", d, 32'h81);
    bus_write(A_STAT, 32'h00);
    bus_read(A_STAT, d); chk("R8 write 0 no effect", d, 32'h81);
    bus_write(A_STAT, 32'h80);
    bus_read(A_STAT, d); chk("R8 done w1c", d, 32'h01);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    chk("R9 masked", {31'h0, irq}, 32'h0);
    bus_write(A_IEN, 32'h80);
    chk("R9 done enabled", {31'h0, irq}, 32'h1);
    bus_read(A_IEN, d); chk("R9 ien readback", d, 32'h80);
    bus_write(A_STAT, 32'h80);
    chk("R9 cause cleared", {31'h0, irq}, 32'h0);
    bus_write(A_IEN, 32'h01);
    chk("R9 tx empty cause", {31'h0, irq}, 32'h1);
    bus_write(A_TXD, 32'h1);
    chk("R9 tx empty gone", {31'h0, irq}, 32'h0);
    tx_pop("R9 pop", 32'h1);
    bus_write(A_IEN, 32'h00);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    bus_write(A_TXD, 32'h11); bus_write(A_TXD, 32'h22);
    for (int i = 0; i < 17; i++) rx_push(32'hC0 + i);
    bus_write(A_TEST, 32'h1 << 22);
    bus_read(A_TEST, d); chk("R10 tx flush only", d, 32'd16 << 5);
    bus_read(A_STAT, d); chk("R10 ovf kept", d, 32'h79);
    bus_write(A_TEST, 32'h1 << 23);
    bus_read(A_TEST, d); chk("R10 rx flush", d, 32'h0);
    bus_read(A_STAT, d); chk("R10 ovf cleared", d, 32'h01);
    bus_write(A_TXD, 32'h33);
    tx_pop("R10 tx usable after flush", 32'h33);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bus_write(A_CTRL, 32'hA5A5_1234);
    bus_read(A_CTRL, d); chk("R11 ctrl readback", d, 32'hA5A5_1234);
    chk("R11 ctrl_o", ctrl_o, 32'hA5A5_1234);
    bus_write(A_PER, 32'hFFFF_FFFF);
    bus_read(A_PER, d); chk("R11 period readback", d, 32'h7FFF);
    chk("R11 period_o", {17'h0, period_o}, 32'h7FFF);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx();
    t_rx();
    t_done();
    t_irq();
    t_flush();
    t_cfg();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule